// File: doc/BRIEF.md
# Triggered Exposure Line Sequencer

This block controls an image sensor in an exposure mode where the start of exposure follows an external trigger rather than the vertical sync. While the mode is on and no trigger has arrived, the sensor is held empty: a charge discharge pulse is issued once per line and the readout pulse stays low. The vertical transfer clocks keep running outside this block, so they flush any charge left in the vertical registers.

A falling edge on the trigger pin passes through a synchroniser. The block then asks for an immediate reset of the horizontal line timebase, issues one last discharge pulse in the same cycle, and counts whole lines from that point. When the programmed number of lines has gone by, it issues the readout pulse and, in the same cycle, a write-enable pulse that marks the first line of image data for a frame store. One line after the readout it waits for a new trigger. For as long as the mode is on, a halt output freezes vertical sync and field generation. At power-up the mode must be held on for at least one clock before normal operation is selected.

Top module: `trig_exposure_seq`

## Requirements
- R1: The trigger input passes through a two-stage synchroniser. A falling edge is acted upon in the cycle that starts at the third rising clock edge, counting the first edge that samples the trigger low as the first. After reset, the synchroniser holds the trigger as high.
- R2: While armed and waiting for a trigger, dischargePulse is high for one cycle in the cycle after each cycle in which lineStrobe is high, and readoutPulse stays low.
- R3: When a trigger falling edge is acted upon while armed, hResetReq is high for exactly one cycle.
- R4: dischargePulse is high in the same cycle as hResetReq. After that it stays low until the sequencer is armed again.
- R5: After the trigger, each lineStrobe adds one line. readoutPulse is high for one cycle in the cycle after the lineStrobe that brings the count to expLines. The comparison uses the value of expLines at each strobe, and an expLines of 0 acts as 1.
- R6: writeEnable is high in exactly the cycles in which readoutPulse is high.
- R7: vsyncHalt equals modeEn delayed by one clock. While modeEn is low, all pulse outputs are low and the sequence is abandoned. The first clock with modeEn high arms the sequencer.
- R8: Trigger edges that arrive between the accepted trigger and the readout pulse produce no hResetReq and no other output.
- R9: After readout, the next lineStrobe produces no discharge and re-arms the sequencer. Later strobes give discharge pulses again, and a trigger edge is accepted from then on.
- R10: rst_n is an asynchronous active-low reset. It clears all outputs and leaves the sequencer unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeEn | input | 1 | Triggered exposure mode on |
| trigIn | input | 1 | External trigger, asynchronous, active on falling edge |
| lineStrobe | input | 1 | One-cycle pulse per line from the line timebase |
| expLines | input | LINE_W | Exposure length in lines |
| hResetReq | output | 1 | Request to reset the horizontal line timebase |
| dischargePulse | output | 1 | Sensor charge discharge pulse |
| readoutPulse | output | 1 | Sensor charge readout pulse |
| writeEnable | output | 1 | Frame store write start, in step with readout |
| vsyncHalt | output | 1 | Freezes vertical sync and field outputs |

## Verification
Every result is due one cycle after the input that causes it, with one exception: the trigger takes three edges to act, so hResetReq and its discharge pulse appear three cycles after the trigger is first sampled low. The bench's reference model tracks the trigger through three integer history slots and updates its expected outputs at each rising edge from the inputs present at that edge. The outputs are compared with it at every falling edge, so each value is checked one register stage after its cause. The stimulus places triggers during exposure and during the re-arm line, sets expLines to 0, and drops the mode in the middle of an exposure, so the cycle-level model covers those cases as well.

// File: rtl/trig_exposure_pkg.sv
package trig_exposure_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_EXPOSE = 2'd2,
    ST_REARM  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } dpCtrl_t;
endpackage

// File: rtl/trig_exposure_dp.sv
module trig_exposure_dp
  import trig_exposure_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigIn,
  input  logic              lineStrobe,
  input  logic [LINE_W-1:0] expLines,
  input  dpCtrl_t           ctrl,
  output logic              trigFall,
  output logic              expDone
);
  localparam int CW = LINE_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   trigPrev;
  logic [LINE_W-1:0]      lineCnt;
  logic [CW-1:0]          nextCnt;

  // Synchroniser chain, idle level is high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncQ[g] <= 1'b1;
      else if (g == 0) syncQ[g] <= trigIn;
      else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trigPrev <= 1'b1;
    else trigPrev <= syncQ[SYNC_STAGES-1];
  end

  assign trigFall = trigPrev & ~syncQ[SYNC_STAGES-1];

  // Exposure line counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lineCnt <= '0;
    else if (ctrl.cntClr) lineCnt <= '0;
    else if (ctrl.cntInc) lineCnt <= lineCnt + 1'b1;
  end

  assign nextCnt = {1'b0, lineCnt} + CW'(1);
  assign expDone = lineStrobe && (nextCnt >= {1'b0, expLines});
endmodule

// File: rtl/trig_exposure_ctrl.sv
module trig_exposure_ctrl
  import trig_exposure_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    modeEn,
  input  logic    lineStrobe,
  input  logic    trigFall,
  input  logic    expDone,
  output dpCtrl_t ctrl,
  output logic    hResetReq,
  output logic    dischargePulse,
  output logic    readoutPulse,
  output logic    writeEnable,
  output logic    vsyncHalt
);
  seqState_t state, stateNext;
  logic      hrNext, disNext, rdNext;

  always_comb begin
    stateNext = state;
    hrNext    = 1'b0;
    disNext   = 1'b0;
    rdNext    = 1'b0;
    ctrl      = '0;
    if (!modeEn) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: stateNext = ST_ARMED;
        ST_ARMED: begin
          if (trigFall) begin
            stateNext   = ST_EXPOSE;
            hrNext      = 1'b1;
            disNext     = 1'b1;
            ctrl.cntClr = 1'b1;
          end else begin
            disNext = lineStrobe;
          end
        end
        ST_EXPOSE: begin
          if (expDone) begin
            stateNext = ST_REARM;
            rdNext    = 1'b1;
          end else if (lineStrobe) begin
            ctrl.cntInc = 1'b1;
          end
        end
        ST_REARM: if (lineStrobe) stateNext = ST_ARMED;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_OFF;
      hResetReq      <= 1'b0;
      dischargePulse <= 1'b0;
      readoutPulse   <= 1'b0;
      writeEnable    <= 1'b0;
      vsyncHalt      <= 1'b0;
    end else begin
      state          <= stateNext;
      hResetReq      <= hrNext;
      dischargePulse <= disNext;
      readoutPulse   <= rdNext;
      writeEnable    <= rdNext;
      vsyncHalt      <= modeEn;
    end
  end
endmodule

// File: rtl/trig_exposure_seq.sv
module trig_exposure_seq
  import trig_exposure_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeEn,
  input  logic              trigIn,
  input  logic              lineStrobe,
  input  logic [LINE_W-1:0] expLines,
  output logic              hResetReq,
  output logic              dischargePulse,
  output logic              readoutPulse,
  output logic              writeEnable,
  output logic              vsyncHalt
);
  dpCtrl_t dpCtrl;
  logic    trigFall;
  logic    expDone;

  trig_exposure_dp #(.LINE_W(LINE_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .lineStrobe(lineStrobe),
    .expLines(expLines), .ctrl(dpCtrl), .trigFall(trigFall), .expDone(expDone)
  );

  trig_exposure_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeEn(modeEn), .lineStrobe(lineStrobe),
    .trigFall(trigFall), .expDone(expDone), .ctrl(dpCtrl),
    .hResetReq(hResetReq), .dischargePulse(dischargePulse),
    .readoutPulse(readoutPulse), .writeEnable(writeEnable),
    .vsyncHalt(vsyncHalt)
  );
endmodule

// File: rtl/trig_exposure_seq_chk.sv
module trig_exposure_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic modeEn,
  input logic hResetReq,
  input logic dischargePulse,
  input logic readoutPulse,
  input logic writeEnable,
  input logic vsyncHalt
);
  p_hreset_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hResetReq |=> !hResetReq);

  p_final_discharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hResetReq |-> dischargePulse);

  p_readout_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    readoutPulse |=> !readoutPulse);

  p_write_with_readout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    readoutPulse |-> writeEnable);

  p_halt_follows_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    modeEn |=> vsyncHalt);

  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vsyncHalt |-> !(hResetReq || dischargePulse || readoutPulse || writeEnable));
endmodule

bind trig_exposure_seq trig_exposure_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .modeEn(modeEn), .hResetReq(hResetReq),
  .dischargePulse(dischargePulse), .readoutPulse(readoutPulse),
  .writeEnable(writeEnable), .vsyncHalt(vsyncHalt)
);

// File: tb/trig_exposure_seq_test.sv
`timescale 1ns/1ps
module trig_exposure_seq_test;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          modeEn = 1'b0;
  logic          trigIn = 1'b1;
  logic          lineStrobe = 1'b0;
  logic [LW-1:0] expLines = LW'(3);
  logic hResetReq, dischargePulse, readoutPulse, writeEnable, vsyncHalt;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  trig_exposure_seq #(.LINE_W(LW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .modeEn(modeEn), .trigIn(trigIn),
    .lineStrobe(lineStrobe), .expLines(expLines), .hResetReq(hResetReq),
    .dischargePulse(dischargePulse), .readoutPulse(readoutPulse),
    .writeEnable(writeEnable), .vsyncHalt(vsyncHalt)
  );

  always #5 clk = ~clk;

  // Behavioural reference: phase 0 off, 1 waiting, 2 counting, 3 one line of rest
  int trigHist[3];
  int phase, lines;
  int eHr, eDis, eRd, eWe, eHalt;

  always @(posedge clk) begin
    int fell;
    if (!rst_n) begin
      trigHist = '{1, 1, 1};
      phase = 0; lines = 0;
      eHr = 0; eDis = 0; eRd = 0; eWe = 0; eHalt = 0;
    end else begin
      fell = (trigHist[2] == 1 && trigHist[1] == 0) ? 1 : 0;
      trigHist[2] = trigHist[1];
      trigHist[1] = trigHist[0];
      trigHist[0] = int'(trigIn);
      eHr = 0; eDis = 0; eRd = 0; eWe = 0;
      eHalt = int'(modeEn);
      if (!modeEn) phase = 0;
      else if (phase == 0) phase = 1;
      else if (phase == 1) begin
        if (fell == 1) begin
          eHr = 1; eDis = 1; lines = 0; phase = 2;
        end else eDis = int'(lineStrobe);
      end else if (phase == 2) begin
        if (lineStrobe) begin
          lines = lines + 1;
          if (lines >= ((expLines == 0) ? 1 : int'(expLines))) begin
            eRd = 1; eWe = 1; phase = 3;
          end
        end
      end else if (lineStrobe) phase = 1;
    end
  end

  task automatic cmp(string tag, logic got, int expv);
    vectors++;
    if (int'(got) != expv) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0b expected %0d", tag, cycles, got, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      cmp("R3 hResetReq", hResetReq, eHr);
      cmp((phase == 1) ? "R2 dischargePulse" : "R4 dischargePulse", dischargePulse, eDis);
      cmp("R5 readoutPulse", readoutPulse, eRd);
      cmp("R6 writeEnable", writeEnable, eWe);
      cmp("R7 vsyncHalt", vsyncHalt, eHalt);
    end
  end

  task automatic line(int gap);
    @(negedge clk); lineStrobe = 1'b1;
    @(negedge clk); lineStrobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pullTrig(int lowCycles);
    @(negedge clk); trigIn = 1'b0;
    repeat (lowCycles) @(negedge clk);
    trigIn = 1'b1;
  endtask

  initial begin
    // R10: outputs quiet under and right after reset
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: enabling the mode arms the sequencer and raises the halt
    modeEn = 1'b1;
    repeat (3) line(6);                       // R2 discharge per line
    // R1/R3/R4: trigger accepted after sync latency
    pullTrig(12);
    line(6);
    pullTrig(4);                              // R8 ignored during exposure
    line(6); line(6);                         // R5 readout after third line
    pullTrig(3);                              // R8/R9 ignored while resting
    line(6);                                  // R9 re-arm line, no discharge
    line(6);                                  // R9 discharge again
    expLines = '0;                            // R5 zero acts as one
    pullTrig(5);
    repeat (4) @(negedge clk);
    line(6); line(6);
    // trigger falling on the same cycle as a strobe
    expLines = LW'(2);
    @(negedge clk); trigIn = 1'b0; lineStrobe = 1'b1;
    @(negedge clk); lineStrobe = 1'b0;
    repeat (6) @(negedge clk); trigIn = 1'b1;
    line(3);
    // R7: drop the mode in mid-exposure, then re-enable
    modeEn = 1'b0;
    line(4);
    pullTrig(4);
    modeEn = 1'b1;
    line(4);
    expLines = LW'(4);
    pullTrig(6);
    repeat (5) line(5);
    // R10: asynchronous reset in mid-run
    @(negedge clk); #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) line(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule